// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a byte-addressed physical request into the sequence of addresses presented on a 13-pin multiplexed DRAM address bus. For each access it drives a row address for one cycle with a row strobe. It then drives one column address per data beat with a column strobe. The bit-to-pin assignment is an interleaved permutation, and it differs between the 32-bit and the 16-bit data-width modes. Only physical address bits 27:0 take part, so the map repeats every 256 MB.

A request is accepted through a valid/ready handshake. It carries a 28-bit address, a length field, and a width select. The length field holds the number of 32-bit words minus one. In 16-bit mode each word takes two column beats. The block generates the half-word select itself and places it on column pin 0. A burst never runs across a minimum page, which is 256 column locations (1 KB in 32-bit mode, 512 bytes in 16-bit mode). When the next word starts a new page, the current access ends and a fresh row phase opens for the rest of the burst. Every larger page size is a multiple of this one, so larger page crossings are split as well.

The sequencer has three states. `ST_IDLE` waits with ready high. `ST_ROW` drives the row address. `ST_COL` drives one column beat per cycle. The transitions are:
- ACCEPT: `ST_IDLE`→`ST_ROW` when valid and ready are both high.
- OPEN: `ST_ROW`→`ST_COL`.
- NEXT_HALF and NEXT_WORD: `ST_COL`→`ST_COL`.
- PAGE_BREAK: `ST_COL`→`ST_ROW` when the next word lies at page offset 0.
- DONE: `ST_COL`→`ST_IDLE` after the beat that ends the last word.

Top module: `dram_addr_mux`

## Requirements
- R1: The asynchronous active-low reset, whether applied idle or mid-burst, forces ready=1, row_stb=0, col_stb=0 and dram_a=0.
- R2: req_ready is 1 only while no access is in progress. A request is taken on a rising edge where req_valid and req_ready are both 1. With req_valid low, nothing starts.
- R3: The cycle after acceptance carries row_stb=1 for exactly one cycle. A column beat (col_stb=1) follows in the next cycle.
- R4: 32-bit row map: pins 0..8 carry address bits 10..18, and pins 9..12 carry bits 20, 22, 24, 26.
- R5: 16-bit row map: pins 0..8 carry address bits 9..17, and pins 9..12 carry bits 19, 21, 23, 25.
- R6: 32-bit column map: pins 0..7 carry address bits 2..9, and pins 8..12 carry bits 19, 21, 23, 25, 27.
- R7: 16-bit column map: pin 0 carries the generated half-word bit, pins 1..7 carry address bits 2..8, and pins 8..12 carry bits 18, 20, 22, 24, 26.
- R8: A length field L transfers L+1 words at consecutive word addresses. Each word is one beat in 32-bit mode (req_wide=1). It is two beats in 16-bit mode (req_wide=0), with the half bit 0 and then 1. The block returns to idle in the cycle after the final beat.
- R9: When the next word's page offset is zero, a new row phase is issued before its column beat. The offset is address bits 9:2 in 32-bit mode and bits 8:2 in 16-bit mode.
- R10: A burst that starts exactly at page offset zero gets a single row phase for that page, with no extra split.
- R11: Word addresses wrap modulo 2^28. A burst from 0xFFFFFFC continues at 0x0000000 with a new row phase.
- R12: row_stb and col_stb are never high together, and dram_a is zero whenever both are low.
- R13: Request address bits 1:0 have no effect on any driven address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | High when idle and able to take a request |
| req_addr | input | 28 | Physical byte address |
| req_len | input | 8 | Number of 32-bit words minus one |
| req_wide | input | 1 | 1 = 32-bit data width, 0 = 16-bit |
| row_stb | output | 1 | Row address phase strobe |
| col_stb | output | 1 | Column address phase strobe |
| dram_a | output | 13 | Multiplexed DRAM address |

## Verification
All outputs are Moore functions of registered state. The row address therefore appears in the cycle after the accepting edge. Each column beat follows one cycle after the previous row or beat, and idle with ready high returns one cycle after the final beat. The bench drives inputs and samples outputs on falling edges. It walks an expected beat list computed from the pin maps and the page rule, one falling edge per expected cycle. A split therefore shows up as an extra row cycle at exactly the position where the offset wraps, and a missing or extra split shifts every later sample.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL
    } seq_state_t;
endpackage

// File: rtl/dram_addr_perm.sv
module dram_addr_perm #(
    parameter int ADDR_W = 28,
    parameter int PIN_W  = 13
) (
    input  logic [ADDR_W-1:2] wa,
    input  logic              wide,
    input  logic              half,
    output logic [PIN_W-1:0]  row_a,
    output logic [PIN_W-1:0]  col_a
);
    localparam int ROW_LO_N = 9;
    localparam int ROW_HI_N = PIN_W - ROW_LO_N;
    localparam int COL_LO_N = 8;
    localparam int COL_HI_N = PIN_W - COL_LO_N;

    // Row: contiguous low run, then every other bit; 32-bit mode is one bit higher.
    for (genvar p = 0; p < ROW_LO_N; p++) begin : g_row_lo
        assign row_a[p] = wide ? wa[10+p] : wa[9+p];
    end
    for (genvar k = 0; k < ROW_HI_N; k++) begin : g_row_hi
        assign row_a[ROW_LO_N+k] = wide ? wa[20+2*k] : wa[19+2*k];
    end

    // Column: in 16-bit mode pin 0 is the generated half-word select.
    for (genvar p = 0; p < COL_LO_N; p++) begin : g_col_lo
        if (p == 0) begin : g_pin0
            assign col_a[p] = wide ? wa[2] : half;
        end else begin : g_pinn
            assign col_a[p] = wide ? wa[2+p] : wa[1+p];
        end
    end
    for (genvar k = 0; k < COL_HI_N; k++) begin : g_col_hi
        assign col_a[COL_LO_N+k] = wide ? wa[19+2*k] : wa[18+2*k];
    end
endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W        = 28,
    parameter int LEN_W         = 8,
    parameter int COL_WORD_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_wide,
    output logic              req_ready,
    output seq_state_t        state,
    output logic [ADDR_W-1:2] word_addr,
    output logic              wide_q,
    output logic              half_q
);
    localparam int WIDE_TOP   = 2 + COL_WORD_BITS - 1;
    localparam int NARROW_TOP = WIDE_TOP - 1;

    seq_state_t       next_state;
    logic [LEN_W-1:0] remain_q;
    logic             accept;
    logic             word_done;
    logic             last_word;
    logic             page_end;
    logic             unused_low;

    assign unused_low = ^req_addr[1:0];
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign word_done  = (state == ST_COL) && (wide_q || half_q);
    assign last_word  = (remain_q == '0);
    assign page_end   = wide_q ? (&word_addr[WIDE_TOP:2]) : (&word_addr[NARROW_TOP:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: if (accept) next_state = ST_ROW;          // ACCEPT
            ST_ROW:  next_state = ST_COL;                       // OPEN
            ST_COL: begin
                if (word_done && last_word)     next_state = ST_IDLE; // DONE
                else if (word_done && page_end) next_state = ST_ROW;  // PAGE_BREAK
                else                            next_state = ST_COL;  // NEXT_HALF / NEXT_WORD
            end
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr <= '0;
            remain_q  <= '0;
            wide_q    <= 1'b0;
            half_q    <= 1'b0;
        end else if (accept) begin
            word_addr <= req_addr[ADDR_W-1:2];
            remain_q  <= req_len;
            wide_q    <= req_wide;
            half_q    <= 1'b0;
        end else if (state == ST_COL) begin
            if (!wide_q) half_q <= ~half_q;
            if (word_done && !last_word) begin
                word_addr <= word_addr + 1'b1;
                remain_q  <= remain_q - 1'b1;
            end
        end
    end

    // R8
    narrow_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COL && !wide_q && !half_q) |=> (state == ST_COL && half_q));
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int LEN_W  = 8,
    parameter int PIN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_wide,
    output logic              row_stb,
    output logic              col_stb,
    output logic [PIN_W-1:0]  dram_a
);
    seq_state_t        state;
    logic [ADDR_W-1:2] word_addr;
    logic              wide_q;
    logic              half_q;
    logic [PIN_W-1:0]  row_a;
    logic [PIN_W-1:0]  col_a;

    dram_burst_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .COL_WORD_BITS(8)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_wide(req_wide), .req_ready(req_ready),
        .state(state), .word_addr(word_addr), .wide_q(wide_q), .half_q(half_q)
    );

    dram_addr_perm #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_perm (
        .wa(word_addr), .wide(wide_q), .half(half_q), .row_a(row_a), .col_a(col_a)
    );

    always_comb begin
        row_stb = 1'b0;
        col_stb = 1'b0;
        dram_a  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ROW: begin
                row_stb = 1'b1;
                dram_a  = row_a;
            end
            ST_COL: begin
                col_stb = 1'b1;
                dram_a  = col_a;
            end
            default: ;
        endcase
    end

    // R3
    accept_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (row_stb && !col_stb));
    // R3
    row_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb |=> col_stb);
    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_stb || col_stb) |-> !req_ready);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_stb, col_stb}));
    // R8
    narrow_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !wide_q && !dram_a[0]) |=>
        (col_stb && dram_a[0] && dram_a[PIN_W-1:1] == $past(dram_a[PIN_W-1:1])));
    // R6
    wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && wide_q && $past(col_stb)) |-> (dram_a[7:0] == 8'($past(dram_a[7:0]) + 8'd1)));
    // R9
    page_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && (&dram_a[7:0])) |=> !col_stb);
endmodule

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic [27:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_ready;
    logic        row_stb;
    logic        col_stb;
    logic [12:0] dram_a;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    dram_addr_mux u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_wide(req_wide),
        .row_stb(row_stb), .col_stb(col_stb), .dram_a(dram_a)
    );

    // {wide, len, addr}
    localparam int NV = 10;
    localparam logic [36:0] VECS [NV] = '{
        {1'b1, 8'd0,   28'h0000004},  // single word, 32-bit
        {1'b1, 8'd3,   28'hA5A5A50},  // short burst, 32-bit
        {1'b0, 8'd1,   28'h5A5A5A4},  // short burst, 16-bit
        {1'b1, 8'd3,   28'h12343F8},  // R9 crosses after two words
        {1'b0, 8'd2,   28'h87651FC},  // R9 16-bit crossing after first word
        {1'b1, 8'd1,   28'h2468400},  // R10 starts on boundary
        {1'b1, 8'd1,   28'hFFFFFFC},  // R11 wrap to zero
        {1'b1, 8'd0,   28'h1357ACB},  // R13 low bits set
        {1'b0, 8'd3,   28'h0000200},  // R10 16-bit boundary start
        {1'b1, 8'd255, 28'h0000010}   // long burst, one crossing
    };

    function automatic logic [12:0] ref_row(logic [27:0] a, logic w);
        logic [12:0] r;
        for (int p = 0; p < 13; p++) begin
            int b;
            if (p < 9) b = (w ? 10 : 9) + p;
            else       b = (w ? 20 : 19) + 2 * (p - 9);
            r[p] = a[b];
        end
        return r;
    endfunction

    function automatic logic [12:0] ref_col(logic [27:0] a, logic w, logic h);
        logic [12:0] r;
        for (int p = 0; p < 13; p++) begin
            if (p == 0)     r[p] = w ? a[2] : h;
            else if (p < 8) r[p] = w ? a[2 + p] : a[1 + p];
            else            r[p] = w ? a[19 + 2 * (p - 8)] : a[18 + 2 * (p - 8)];
        end
        return r;
    endfunction

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic expect_cyc(input logic [15:0] exp, input string tag);
        @(negedge clk);
        check({req_ready, row_stb, col_stb, dram_a}, exp, tag);
    endtask

    // Called just after a falling edge; drives there and checks every later falling edge.
    task automatic run_req(input logic [27:0] a, input logic [7:0] len, input logic w, input int vi);
        logic [27:0] cur;
        string       sfx;
        sfx = $sformatf(" vec%0d", vi);
        req_addr  = a;
        req_len   = len;
        req_wide  = w;
        req_valid = 1'b1;
        cur = {a[27:2], 2'b00};
        for (int wi = 0; wi <= int'(len); wi++) begin
            if (wi == 0) begin
                expect_cyc({3'b010, ref_row(cur, w)}, {w ? "R3 R4 first row" : "R3 R5 first row", sfx});
                req_valid = 1'b0;
            end else if (w ? (cur[9:2] == 8'd0) : (cur[8:2] == 7'd0)) begin
                expect_cyc({3'b010, ref_row(cur, w)}, {"R9 page split row", sfx});
            end
            for (int h = 0; h < (w ? 1 : 2); h++) begin
                expect_cyc({3'b001, ref_col(cur, w, h[0])},
                           {w ? "R6 R8 column beat" : "R7 R8 column beat", sfx});
            end
            cur = cur + 28'd4;
        end
        expect_cyc({1'b1, 15'b0}, {"R8 R12 idle after last beat", sfx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check({req_ready, row_stb, col_stb, dram_a}, {1'b1, 15'b0}, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: valid low, nothing starts
        for (int i = 0; i < 3; i++) expect_cyc({1'b1, 15'b0}, "R2 R12 idle without valid");

        for (int v = 0; v < NV; v++) begin
            run_req(VECS[v][27:0], VECS[v][35:28], VECS[v][36], v);
        end

        // R1: reset in the middle of a burst
        req_addr  = 28'h0ABCDE0;
        req_len   = 8'd5;
        req_wide  = 1'b1;
        req_valid = 1'b1;
        expect_cyc({3'b010, ref_row(28'h0ABCDE0, 1'b1)}, "R3 R4 row before reset");
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check({req_ready, row_stb, col_stb, dram_a}, {1'b1, 15'b0}, "R1 reset mid-burst");
        @(negedge clk);
        rst_n = 1'b1;
        expect_cyc({1'b1, 15'b0}, "R1 idle after reset release");
        run_req(28'h3000000, 8'd0, 1'b0, 99);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule